// File: doc/BRIEF.md
# Shift-Register Bit-Line/Word-Line Programming Bank

This block programs a two-dimensional array of configuration cells. The cells are addressed as bit-line columns crossed with word-line rows. Column data and a row select are streamed in serially over two sets of shift-register chains, one set for bit-lines and one for word-lines. Either set may be split into several independent chains of near-equal length. Once the chains hold a full load, the block raises a single-cycle write pulse. During that pulse exactly one row is enabled, and every real cell on that row captures the value on its bit-line. Each cell drives a true output and an inverted output.

The array shape is derived from the number of configuration bits. By default the column count is the ceiling of the square root of the bit count, and the row count follows from it. A fixed row count may be set instead. Array positions beyond the bit count are padding: they are never connected to an output. A host programs the whole array by repeating one load per row.

Top module: `cbank_sr_prog`

## Requirements
- R1: With `FIXED_WL` = 0, the column count is BL_N = ceil(sqrt(NUM_BITS)) and the row count is WL_N = ceil(NUM_BITS/BL_N). Configuration bit i belongs to row i/BL_N and column i%BL_N (14 bits give 4 columns by 4 rows).
- R2: With `FIXED_WL` > 0, WL_N = FIXED_WL and BL_N = ceil(NUM_BITS/FIXED_WL). For example, 10 bits with 3 rows give 4 columns.
- R3: An array position with index i >= NUM_BITS is padding and has no output. Writing a row that contains padding columns changes only that row's real bits.
- R4: The lines of each set are divided into contiguous banks in ascending order. Bank b has floor(L/B) lines, plus one more when b < L%B. Every bank shifts once per accepted shift cycle. After a load, a bank holds the last bits it received, and the earliest of those bits lands on the bank's highest line (MSB first). One load is LOAD_LEN accepted shifts, where LOAD_LEN is the longest bank in either set.
- R5: `write_o` goes high for exactly one cycle: the cycle after the shift that brings the total count of accepted shifts to LOAD_LEN. The shifts need not be contiguous. No write happens before the count is reached.
- R6: `wl_o` is all zero in every cycle in which `write_o` is low.
- R7: During the write pulse only the lowest-index word-line that holds a 1 is driven. If the word-line chains hold all zeros, no row is written.
- R8: On the write pulse, each cell on the driven row stores its bit-line value. `cfg_o` shows the new value from the following cycle, and `cfg_no` is its bitwise inverse.
- R9: `shift_en_i` is ignored during the write-pulse cycle. The chains keep their contents and the shift count does not advance.
- R10: While `rst_ni` is low, `cfg_o` is all zero, `cfg_no` is all one, and `write_o` and `wl_o` are zero. The shift count is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Programming clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | 1 | Shift all chains one position this cycle |
| bl_sdi_i | input | BL_BANKS | Serial data, one bit per bit-line chain |
| wl_sdi_i | input | WL_BANKS | Serial data, one bit per word-line chain |
| bl_o | output | BL_N | Bit-line values held in the chains |
| wl_o | output | WL_N | Gated word-line row enables |
| write_o | output | 1 | Write pulse, one cycle per completed load |
| cfg_o | output | NUM_BITS | Configuration cell outputs |
| cfg_no | output | NUM_BITS | Inverted configuration cell outputs |

## Verification
The hardest situation to reach from the ports is a stray shift request during the write-pulse cycle. If such a shift were wrongly counted, the next write would fire one shift early, and that early firing is the only visible trace of the error. The bench therefore holds `shift_en_i` high through some write cycles and then checks that no write pulse appears until a full fresh load has been shifted. It also splits a load across a pause to show that the count accumulates. A second instance, with a fixed row count and two chains per set of unequal length, exercises the bank split and the padding columns.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int ceil_sqrt(input int n);
    int r;
    r = 0;
    for (int i = 0; i <= n; i++) begin
      if (i * i < n) r = i + 1;
    end
    return r;
  endfunction

  function automatic int bl_lines(input int nbits, input int fixed_wl);
    return (fixed_wl > 0) ? ceil_div(nbits, fixed_wl) : ceil_sqrt(nbits);
  endfunction

  function automatic int wl_lines(input int nbits, input int fixed_wl);
    return (fixed_wl > 0) ? fixed_wl : ceil_div(nbits, bl_lines(nbits, fixed_wl));
  endfunction

  function automatic int bank_len(input int lines, input int banks, input int b);
    return lines / banks + ((b < lines % banks) ? 1 : 0);
  endfunction

  function automatic int bank_base(input int lines, input int banks, input int b);
    return b * (lines / banks) + ((b < lines % banks) ? b : lines % banks);
  endfunction

  function automatic int load_len(input int bl_n, input int bl_b, input int wl_n, input int wl_b);
    int a;
    int c;
    a = ceil_div(bl_n, bl_b);
    c = ceil_div(wl_n, wl_b);
    return (a > c) ? a : c;
  endfunction

endpackage

// File: rtl/cbank_chain.sv
module cbank_chain #(
  parameter int LINES = 4,
  parameter int BANKS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [BANKS-1:0] sdi_i,
  output logic [LINES-1:0] lines_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int LEN  = cbank_pkg::bank_len(LINES, BANKS, b);
    localparam int BASE = cbank_pkg::bank_base(LINES, BANKS, b);
    logic [LEN-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (shift_i) sr_q <= LEN'({sr_q, sdi_i[b]});
    end

    assign lines_o[BASE +: LEN] = sr_q;
  end
endmodule

// File: rtl/cbank_ctrl.sv
module cbank_ctrl #(
  parameter int LOAD_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_req_i,
  output logic shift_go_o,
  output logic write_o
);
  localparam int CW = $clog2(LOAD_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          wr_q;

  // shifting is blocked during the write pulse
  assign shift_go_o = shift_req_i && !wr_q;
  assign write_o    = wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (shift_go_o) begin
        if (cnt_q == CW'(LOAD_LEN - 1)) begin
          cnt_q <= '0;
          wr_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cbank_cells.sv
module cbank_cells #(
  parameter int NUM_BITS = 14,
  parameter int BL_N     = 4,
  parameter int WL_N     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BL_N-1:0]     bl_i,
  input  logic [WL_N-1:0]     wl_i,
  output logic [NUM_BITS-1:0] cfg_o,
  output logic [NUM_BITS-1:0] cfg_no
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    localparam int ROW = i / BL_N;
    localparam int COL = i % BL_N;
    logic q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= 1'b0;
      else if (wl_i[ROW]) q <= bl_i[COL];
    end

    assign cfg_o[i]  = q;
    assign cfg_no[i] = ~q;
  end
endmodule

// File: rtl/cbank_sr_prog.sv
module cbank_sr_prog
  import cbank_pkg::*;
#(
  parameter  int NUM_BITS = 14,
  parameter  int FIXED_WL = 0,
  parameter  int BL_BANKS = 1,
  parameter  int WL_BANKS = 1,
  localparam int BL_N     = bl_lines(NUM_BITS, FIXED_WL),
  localparam int WL_N     = wl_lines(NUM_BITS, FIXED_WL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic [BL_BANKS-1:0] bl_sdi_i,
  input  logic [WL_BANKS-1:0] wl_sdi_i,
  output logic [BL_N-1:0]     bl_o,
  output logic [WL_N-1:0]     wl_o,
  output logic                write_o,
  output logic [NUM_BITS-1:0] cfg_o,
  output logic [NUM_BITS-1:0] cfg_no
);
  localparam int LOAD_LEN = load_len(BL_N, BL_BANKS, WL_N, WL_BANKS);

  logic            shift_go;
  logic [WL_N-1:0] wl_raw;
  logic [WL_N-1:0] wl_pick;

  cbank_ctrl #(.LOAD_LEN(LOAD_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_req_i(shift_en_i),
    .shift_go_o (shift_go),
    .write_o    (write_o)
  );

  cbank_chain #(.LINES(BL_N), .BANKS(BL_BANKS)) u_bl_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_go),
    .sdi_i  (bl_sdi_i),
    .lines_o(bl_o)
  );

  cbank_chain #(.LINES(WL_N), .BANKS(WL_BANKS)) u_wl_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_go),
    .sdi_i  (wl_sdi_i),
    .lines_o(wl_raw)
  );

  // keep only the lowest set row, and gate every row outside the write pulse
  assign wl_pick = wl_raw & (~wl_raw + WL_N'(1));
  assign wl_o    = write_o ? wl_pick : '0;

  cbank_cells #(.NUM_BITS(NUM_BITS), .BL_N(BL_N), .WL_N(WL_N)) u_cells (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bl_i  (bl_o),
    .wl_i  (wl_o),
    .cfg_o (cfg_o),
    .cfg_no(cfg_no)
  );
endmodule

// File: rtl/cbank_sr_prog_chk.sv
module cbank_sr_prog_chk #(
  parameter int NUM_BITS = 14,
  parameter int BL_N     = 4,
  parameter int WL_N     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                shift_en_i,
  input logic [BL_N-1:0]     bl_o,
  input logic [WL_N-1:0]     wl_o,
  input logic                write_o,
  input logic [NUM_BITS-1:0] cfg_o,
  input logic [NUM_BITS-1:0] cfg_no
);
  AST_WL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_o |-> (wl_o == '0)); // R6

  AST_WL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_o)); // R7

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> !write_o); // R5

  AST_PULSE_AFTER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |-> $past(shift_en_i)); // R5

  AST_BL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> $stable(bl_o)); // R9

  AST_CFG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_o |=> $stable(cfg_o)); // R8

  AST_CFG_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_o) |-> $stable(cfg_no)); // R8
endmodule

bind cbank_sr_prog cbank_sr_prog_chk #(
  .NUM_BITS(NUM_BITS), .BL_N(BL_N), .WL_N(WL_N)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_en_i(shift_en_i),
  .bl_o      (bl_o),
  .wl_o      (wl_o),
  .write_o   (write_o),
  .cfg_o     (cfg_o),
  .cfg_no    (cfg_no)
);

// File: tb/tb_cbank_sr_prog.sv
`timescale 1ns/1ps
module tb_cbank_sr_prog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // instance A: 14 bits, square sizing, one chain per set
  logic       shift_a = 1'b0;
  logic [0:0] bl_sdi_a = '0, wl_sdi_a = '0;
  logic [3:0] bl_a, wl_a;
  logic       wr_a;
  logic [13:0] cfg_a, cfgn_a, exp_a;

  // instance B: 10 bits, 3 fixed rows, two chains per set
  logic       shift_b = 1'b0;
  logic [1:0] bl_sdi_b = '0, wl_sdi_b = '0;
  logic [3:0] bl_b;
  logic [2:0] wl_b;
  logic       wr_b;
  logic [9:0] cfg_b, cfgn_b, exp_b;

  cbank_sr_prog dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_a),
    .bl_sdi_i(bl_sdi_a), .wl_sdi_i(wl_sdi_a),
    .bl_o(bl_a), .wl_o(wl_a), .write_o(wr_a),
    .cfg_o(cfg_a), .cfg_no(cfgn_a)
  );

  cbank_sr_prog #(.NUM_BITS(10), .FIXED_WL(3), .BL_BANKS(2), .WL_BANKS(2)) dut2 (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_b),
    .bl_sdi_i(bl_sdi_b), .wl_sdi_i(wl_sdi_b),
    .bl_o(bl_b), .wl_o(wl_b), .write_o(wr_b),
    .cfg_o(cfg_b), .cfg_no(cfgn_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic sbit(input int ln, input int nb, input int len_all, input int k,
                                input int b, input logic [3:0] v);
    int len, base, p;
    len  = ln / nb + ((b < ln % nb) ? 1 : 0);
    base = b * (ln / nb) + ((b < ln % nb) ? b : ln % nb);
    p    = len_all - 1 - k;
    return (p < len) ? v[base + p] : 1'b0;
  endfunction

  // one full load plus write; extra keeps shift high through the write cycle
  task automatic do_load(input int sel, input logic [3:0] bl, input logic [3:0] wl, input bit extra);
    int L, nbits, wln, row;
    logic [3:0] wl_exp;
    L     = sel ? 2 : 4;
    nbits = sel ? 10 : 14;
    wln   = sel ? 3 : 4;
    row   = -1;
    for (int r = wln - 1; r >= 0; r--) if (wl[r]) row = r;
    wl_exp = (row >= 0) ? (4'd1 << row) : 4'd0;
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      if (sel == 0) chk(!wr_a && wl_a == 0, "R6 R9 gated while loading", {wr_a, wl_a}, 0);
      else          chk(!wr_b && wl_b == 0, "R6 R9 gated while loading", {wr_b, wl_b}, 0);
      if (sel == 0) begin
        shift_a = 1'b1;
        bl_sdi_a[0] = sbit(4, 1, 4, k, 0, bl);
        wl_sdi_a[0] = sbit(4, 1, 4, k, 0, wl);
      end else begin
        shift_b = 1'b1;
        for (int b = 0; b < 2; b++) begin
          bl_sdi_b[b] = sbit(4, 2, 2, k, b, bl);
          wl_sdi_b[b] = sbit(3, 2, 2, k, b, wl);
        end
      end
    end
    @(negedge clk);
    if (extra) begin
      bl_sdi_a = '1; wl_sdi_a = '1; bl_sdi_b = '1; wl_sdi_b = '1;
    end else begin
      shift_a = 1'b0; shift_b = 1'b0;
    end
    if (sel == 0) begin
      chk(wr_a, "R5 pulse after full load", wr_a, 1);
      chk(wl_a == wl_exp, "R7 row select", wl_a, wl_exp);
      chk(bl_a == bl, "R4 bl order", bl_a, bl);
    end else begin
      chk(wr_b, "R5 pulse after full load", wr_b, 1);
      chk(wl_b == wl_exp[2:0], "R7 row select", wl_b, wl_exp);
      chk(bl_b == bl, "R4 bl order banked", bl_b, bl);
    end
    if (row >= 0)
      for (int c = 0; c < 4; c++)
        if (row * 4 + c < nbits) begin
          if (sel == 0) exp_a[row * 4 + c] = bl[c];
          else          exp_b[row * 4 + c] = bl[c];
        end
    @(negedge clk);
    shift_a = 1'b0; shift_b = 1'b0;
    if (sel == 0) begin
      chk(!wr_a, "R5 one-cycle pulse", wr_a, 0);
      chk(cfg_a == exp_a, (row == 3) ? "R1 R3 R8 cells" : "R1 R8 cells", cfg_a, exp_a);
      chk(cfgn_a == ~exp_a, "R8 inverted out", cfgn_a, ~exp_a);
    end else begin
      chk(!wr_b, "R5 one-cycle pulse", wr_b, 0);
      chk(cfg_b == exp_b, (row == 2) ? "R2 R3 R8 cells" : "R2 R8 cells", cfg_b, exp_b);
      chk(cfgn_b == ~exp_b, "R8 inverted out", cfgn_b, ~exp_b);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_a = '0;
    exp_b = '0;
    repeat (3) @(negedge clk);
    chk(cfg_a == 0 && cfgn_a == 14'h3fff, "R10 reset cells", {cfg_a, cfgn_a}, {14'h0, 14'h3fff});
    chk(!wr_a && wl_a == 0 && !wr_b && wl_b == 0, "R10 reset strobes", {wr_a, wl_a, wr_b, wl_b}, 0);
    rst_n = 1'b1;

    // exhaustive row x pattern sweep, some with stray shift in write cycle
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 16; v++)
        do_load(0, 4'(v), 4'd1 << r, (v % 3) == 0);
    for (int r = 0; r < 3; r++)
      for (int v = 0; v < 16; v++)
        do_load(1, 4'(15 - v), 4'd1 << r, (v % 4) == 1);

    // several word-lines set: lowest wins
    do_load(0, 4'h5, 4'b1010, 1'b0);
    do_load(0, 4'hc, 4'b1100, 1'b0);
    do_load(1, 4'h9, 4'b0110, 1'b0);

    // split load with a pause, all-zero row select
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      shift_a = 1'b1; bl_sdi_a = 1'b1; wl_sdi_a = 1'b0;
    end
    @(negedge clk);
    shift_a = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!wr_a, "R5 no write on partial load", wr_a, 0);
      @(negedge clk);
    end
    shift_a = 1'b1;
    @(negedge clk);
    shift_a = 1'b0;
    chk(wr_a, "R5 count accumulates over pause", wr_a, 1);
    chk(wl_a == 0, "R7 empty row select", wl_a, 0);
    @(negedge clk);
    chk(cfg_a == exp_a, "R7 nothing written", cfg_a, exp_a);

    // stray shift then verify next write needs a full load
    do_load(0, 4'h6, 4'b0100, 1'b1);
    do_load(0, 4'h9, 4'b0001, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule